// File: doc/BRIEF.md
# Six-Channel Column Word Loader

This block is the digital front end of a six-channel column driver. One 10-bit word bus (bit 9 most significant) feeds six channels, each made of a first-stage holding register and a second-stage output register. Words reach the first stage in one of two ways. In addressed mode the 3-bit channel address names the target channel and the start/select input acts as a chip select. In sequenced mode, chosen by address 111, a start pulse arms a small sequencer that hands out six load slots in ascending or descending channel order.

A transfer strobe copies all six first-stage words into the output registers on one falling clock edge, so every output changes at the same moment. An edge-select input sets whether a sequenced word is taken from the bus at the rising or at the falling clock edge. Several such blocks can share one bus, either through separate start pulses or through separate chip selects. A standby input clears all stored data.

The sequencer is a two-state machine. `SEQ_IDLE` moves to `SEQ_RUN` on the *start* transition (address 111 and start high at a rising edge). `SEQ_RUN` stays in place on each *step* transition, where one slot is consumed and the channel index moves by one. It returns to `SEQ_IDLE` on the *done* transition after the sixth slot, or on the *abort* transition when the address leaves 111. A *restart* transition (start seen again while running) reloads the first channel index.

Top module: `col_load_ctrl`

## Requirements
- R1: While `stby` is high, both register stages of every channel are zero and `out_words` reads zero. Clearing takes effect without waiting for a clock edge.
- R2: If a rising edge samples `chan_addr` in the range 0 to 5 with `start_cs` high, the following falling edge writes the `word_in` present at that falling edge into the first stage of channel `chan_addr`.
- R3: A rising edge that samples address 6, or an address from 0 to 5 with `start_cs` low, causes no first-stage write.
- R4: A rising edge that samples address 7 with `start_cs` high starts a sequence, and each of the next six rising edges is one load slot. The slots go to channels 0,1,2,3,4,5 if `dir_down` was low at the start edge, and to 5,4,3,2,1,0 if it was high.
- R5: If `edge_rise` is high at a slot's rising edge, the word loaded is the `word_in` present at that rising edge. If `edge_rise` is low, the word loaded is the `word_in` present at the following falling edge.
- R6: After the sixth slot the sequencer is idle, and no further word is loaded until a new start.
- R7: A rising edge that samples an address other than 7 ends a running sequence. Later slots are not resumed without a new start.
- R8: If a rising edge samples `xfer` high, all six output registers take their first-stage contents at the next falling edge, including any word written at that same edge. Otherwise the outputs hold, and they never change at a rising edge.
- R9: With `start_cs` and `xfer` held high and a channel addressed, that channel's output takes the new `word_in` at every falling edge.
- R10: Channel c appears on `out_words[10c+9:10c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges are used |
| stby | input | 1 | Standby, active high; clears all stored words |
| word_in | input | 10 | Incoming data word, bit 9 most significant |
| edge_rise | input | 1 | High: sequenced words taken at the rising edge; low: at the falling edge |
| dir_down | input | 1 | Sequence direction: low counts 0 up to 5, high counts 5 down to 0 |
| chan_addr | input | 3 | 0 to 5 address a channel, 6 selects nothing, 7 selects sequenced mode |
| start_cs | input | 1 | Start pulse in sequenced mode, chip select in addressed mode |
| xfer | input | 1 | Transfer strobe, sampled at the rising edge |
| out_words | output | 60 | Six output words, channel c at bits 10c+9 to 10c |

## Verification
The hardest situation to reach is a falling-edge sequence run in reverse, where the rising-edge word and the falling-edge word differ in every slot, and the transfer comes in the same cycle as the last slot. Only that case shows both which bus phase was taken and whether the final word gets into the same transfer. The stimulus table drives different values in the two half cycles of every step. It runs one ascending rising-edge sequence and one descending falling-edge sequence, each with the strobe on its last slot. Directed runs then break off a sequence by changing the address, and check the outputs just after every rising edge to confirm that nothing moves there.

// File: rtl/col_load_pkg.sv
package col_load_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/col_load_seq.sv
// Rising-edge side: samples the control pins, runs the slot sequencer and
// hands load requests to the falling-edge register bank.
module col_load_seq
    import col_load_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 3,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              stby,
    input  logic [DATA_W-1:0] word_in,
    input  logic              edge_rise,
    input  logic              dir_down,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic              start_cs,
    input  logic              xfer,
    output logic              pend_vld,
    output logic [CH_W-1:0]   pend_ch,
    output logic [DATA_W-1:0] pend_data,
    output logic              fslot_vld,
    output logic [CH_W-1:0]   fslot_ch,
    output logic              xfer_q
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_t      state, state_nx;
    logic [CH_W-1:0] idx, idx_nx;
    logic [CH_W-1:0] cnt, cnt_nx;
    logic            dir_q, dir_nx;

    logic seq_mode;
    logic slot;
    logic addr_hit;

    assign seq_mode = (chan_addr == {ADDR_W{1'b1}});
    assign slot     = (state == SEQ_RUN) && seq_mode && !start_cs;
    assign addr_hit = !seq_mode && start_cs && (int'(chan_addr) < NUM_CH);

    // state register
    always_ff @(posedge clk or posedge stby) begin
        if (stby) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            cnt   <= '0;
            dir_q <= 1'b0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            cnt   <= cnt_nx;
            dir_q <= dir_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        cnt_nx   = cnt;
        dir_nx   = dir_q;
        if (seq_mode && start_cs) begin
            // start / restart
            state_nx = SEQ_RUN;
            idx_nx   = dir_down ? LAST_CH : '0;
            cnt_nx   = '0;
            dir_nx   = dir_down;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    state_nx = SEQ_IDLE;
                end
                SEQ_RUN: begin
                    if (!seq_mode) begin
                        state_nx = SEQ_IDLE;            // abort
                    end else if (cnt == LAST_CH) begin
                        state_nx = SEQ_IDLE;            // done
                    end else begin
                        cnt_nx = cnt + CH_W'(1);        // step
                        idx_nx = dir_q ? (idx - CH_W'(1)) : (idx + CH_W'(1));
                    end
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

    // output process: load requests for the falling-edge bank
    always_ff @(posedge clk or posedge stby) begin
        if (stby) begin
            pend_vld  <= 1'b0;
            pend_ch   <= '0;
            pend_data <= '0;
            fslot_vld <= 1'b0;
            fslot_ch  <= '0;
            xfer_q    <= 1'b0;
        end else begin
            pend_vld  <= slot && edge_rise;
            pend_ch   <= idx;
            pend_data <= word_in;
            fslot_vld <= (slot && !edge_rise) || addr_hit;
            fslot_ch  <= slot ? idx : chan_addr[CH_W-1:0];
            xfer_q    <= xfer;
        end
    end

    // R4: a running sequence always points at a real channel
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (stby)
        (state == SEQ_RUN) |-> (int'(idx) < NUM_CH));

    // R4: each non-final slot moves the index one step in the latched direction
    a_r4_step_dir: assert property (@(posedge clk) disable iff (stby)
        (slot && (cnt != LAST_CH)) |=>
        (idx == ($past(dir_q) ? ($past(idx) - CH_W'(1)) : ($past(idx) + CH_W'(1)))));

    // R6: the sixth slot returns the sequencer to idle
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (stby)
        (slot && (cnt == LAST_CH)) |=> (state == SEQ_IDLE));

    // R7: leaving address 7 ends the sequence
    a_r7_abort: assert property (@(posedge clk) disable iff (stby)
        !seq_mode |=> (state == SEQ_IDLE));

endmodule

// File: rtl/col_load_bank.sv
// Falling-edge side: six first-stage registers and six output registers.
module col_load_bank #(
    parameter int DATA_W = 10,
    parameter int NUM_CH = 6,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     stby,
    input  logic [DATA_W-1:0]        word_in,
    input  logic                     pend_vld,
    input  logic [CH_W-1:0]          pend_ch,
    input  logic [DATA_W-1:0]        pend_data,
    input  logic                     fslot_vld,
    input  logic [CH_W-1:0]          fslot_ch,
    input  logic                     xfer_q,
    output logic [NUM_CH*DATA_W-1:0] out_words
);

    logic [NUM_CH-1:0][DATA_W-1:0] stg1, stg1_nx, stg2;
    logic [NUM_CH-1:0]             hit_p, hit_f;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign hit_p[c] = pend_vld  && (pend_ch  == CH_W'(c));
        assign hit_f[c] = fslot_vld && (fslot_ch == CH_W'(c));
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            stg1_nx[c] = stg1[c];
            if (hit_p[c]) stg1_nx[c] = pend_data;
            if (hit_f[c]) stg1_nx[c] = word_in;
        end
    end

    always_ff @(negedge clk or posedge stby) begin
        if (stby) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= stg1_nx;
            if (xfer_q) stg2 <= stg1_nx;
        end
    end

    assign out_words = stg2;

    // R1: standby holds every output at zero
    always @(posedge clk) begin
        if (stby) begin
            a_r1_clear: assert (out_words == '0);
        end
    end

    // R8: without a sampled transfer the outputs do not move
    a_r8_hold: assert property (@(negedge clk) disable iff (stby)
        !xfer_q |=> $stable(out_words));

    // R3: with no load request the first stage does not move
    a_r3_no_load: assert property (@(negedge clk) disable iff (stby)
        (!pend_vld && !fslot_vld) |=> $stable(stg1));

    // R2: at most one channel written per edge from each request path
    a_r2_single_target: assert property (@(negedge clk) disable iff (stby)
        $onehot0(hit_p) && $onehot0(hit_f));

endmodule

// File: rtl/col_load_ctrl.sv
module col_load_ctrl #(
    parameter int DATA_W = 10,
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     stby,
    input  logic [DATA_W-1:0]        word_in,
    input  logic                     edge_rise,
    input  logic                     dir_down,
    input  logic [ADDR_W-1:0]        chan_addr,
    input  logic                     start_cs,
    input  logic                     xfer,
    output logic [NUM_CH*DATA_W-1:0] out_words
);

    localparam int CH_W = $clog2(NUM_CH);

    logic              pend_vld;
    logic [CH_W-1:0]   pend_ch;
    logic [DATA_W-1:0] pend_data;
    logic              fslot_vld;
    logic [CH_W-1:0]   fslot_ch;
    logic              xfer_q;

    col_load_seq #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .stby      (stby),
        .word_in   (word_in),
        .edge_rise (edge_rise),
        .dir_down  (dir_down),
        .chan_addr (chan_addr),
        .start_cs  (start_cs),
        .xfer      (xfer),
        .pend_vld  (pend_vld),
        .pend_ch   (pend_ch),
        .pend_data (pend_data),
        .fslot_vld (fslot_vld),
        .fslot_ch  (fslot_ch),
        .xfer_q    (xfer_q)
    );

    col_load_bank #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_bank (
        .clk       (clk),
        .stby      (stby),
        .word_in   (word_in),
        .pend_vld  (pend_vld),
        .pend_ch   (pend_ch),
        .pend_data (pend_data),
        .fslot_vld (fslot_vld),
        .fslot_ch  (fslot_ch),
        .xfer_q    (xfer_q),
        .out_words (out_words)
    );

endmodule

// File: tb/col_load_ctrl_tb.sv
module col_load_ctrl_tb;

    localparam int CLK_P = 10;
    localparam int NCH   = 6;
    localparam int DW    = 10;

    typedef struct packed {
        logic       erise;
        logic       dir;
        logic [2:0] addr;
        logic       cs;
        logic       xfr;
        logic [9:0] wr;
        logic [9:0] wf;
    } vec_t;

    // sequence A: ascending, rising-edge capture, transfer on last slot
    // sequence B: descending, falling-edge capture, transfer on last slot
    localparam int NVEC = 16;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b0, 3'd7, 1'b1, 1'b0, 10'd0,   10'd0},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 10'd100, 10'd500},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 10'd101, 10'd501},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 10'd102, 10'd502},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 10'd103, 10'd503},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 10'd104, 10'd504},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b1, 10'd105, 10'd505},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b1, 10'd999, 10'd998},
        '{1'b0, 1'b1, 3'd7, 1'b1, 1'b0, 10'd0,   10'd0},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 10'd300, 10'd200},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 10'd301, 10'd201},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 10'd302, 10'd202},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 10'd303, 10'd203},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 10'd304, 10'd204},
        '{1'b0, 1'b1, 3'd7, 1'b0, 1'b1, 10'd305, 10'd205},
        '{1'b0, 1'b1, 3'd6, 1'b0, 1'b1, 10'd7,   10'd7}
    };

    logic              clk = 1'b0;
    logic              stby;
    logic [DW-1:0]     word_in;
    logic              edge_rise;
    logic              dir_down;
    logic [2:0]        chan_addr;
    logic              start_cs;
    logic              xfer;
    logic [NCH*DW-1:0] out_words;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    int m_s1 [NCH];
    int m_s2 [NCH];
    bit m_run;
    int m_idx;
    int m_cnt;
    bit m_dir;
    bit m_pv;
    int m_pc;
    int m_pd;
    bit m_fv;
    int m_fc;
    bit m_xq;

    always #(CLK_P/2) clk = ~clk;

    col_load_ctrl u_dut (
        .clk       (clk),
        .stby      (stby),
        .word_in   (word_in),
        .edge_rise (edge_rise),
        .dir_down  (dir_down),
        .chan_addr (chan_addr),
        .start_cs  (start_cs),
        .xfer      (xfer),
        .out_words (out_words)
    );

    function automatic vec_t mk(input bit er, input bit dr, input int ad, input bit cs,
                                input bit xf, input int wr, input int wf);
        vec_t v;
        v.erise = er;
        v.dir   = dr;
        v.addr  = 3'(ad);
        v.cs    = cs;
        v.xfr   = xf;
        v.wr    = 10'(wr);
        v.wf    = 10'(wf);
        return v;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            m_s1[c] = 0;
            m_s2[c] = 0;
        end
        m_run = 0; m_idx = 0; m_cnt = 0; m_dir = 0;
        m_pv = 0; m_pc = 0; m_pd = 0; m_fv = 0; m_fc = 0; m_xq = 0;
    endtask

    task automatic model_rise(input vec_t v);
        m_pv = 0;
        m_fv = 0;
        if (v.addr != 3'd7) begin
            m_run = 0;
            if (v.cs && v.addr <= 3'd5) begin
                m_fv = 1;
                m_fc = int'(v.addr);
            end
        end else if (v.cs) begin
            m_run = 1;
            m_dir = v.dir;
            m_idx = v.dir ? NCH - 1 : 0;
            m_cnt = 0;
        end else if (m_run) begin
            if (v.erise) begin
                m_pv = 1; m_pc = m_idx; m_pd = int'(v.wr);
            end else begin
                m_fv = 1; m_fc = m_idx;
            end
            if (m_cnt == NCH - 1) begin
                m_run = 0;
            end else begin
                m_cnt = m_cnt + 1;
                m_idx = m_dir ? m_idx - 1 : m_idx + 1;
            end
        end
        m_xq = v.xfr;
    endtask

    task automatic model_fall(input int wf);
        if (m_pv) m_s1[m_pc] = m_pd;
        if (m_fv) m_s1[m_fc] = wf;
        if (m_xq) begin
            for (int c = 0; c < NCH; c++) m_s2[c] = m_s1[c];
        end
    endtask

    task automatic check_outs(input string tag);
        bit bad = 0;
        n_checks++;
        for (int c = 0; c < NCH; c++) begin
            if (int'(out_words[c*DW +: DW]) != m_s2[c]) begin
                bad = 1;
                $display("FAIL %s ch%0d: actual %0d expected %0d", tag, c,
                         out_words[c*DW +: DW], m_s2[c]);
            end
        end
        if (bad) n_errors++;
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // one clock cycle; called just after a falling edge
    task automatic step(input vec_t v, input string tag);
        edge_rise = v.erise;
        dir_down  = v.dir;
        chan_addr = v.addr;
        start_cs  = v.cs;
        xfer      = v.xfr;
        word_in   = v.wr;
        model_rise(v);
        @(posedge clk);
        #1;
        check_outs("R8 no change at rising edge");
        word_in = v.wf;
        @(negedge clk);
        #1;
        model_fall(int'(v.wf));
        check_outs(tag);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        stby      = 1'b1;
        word_in   = '0;
        edge_rise = 1'b1;
        dir_down  = 1'b0;
        chan_addr = 3'd6;
        start_cs  = 1'b0;
        xfer      = 1'b0;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        #1;
        check_outs("R1 reset state");
        stby = 1'b0;

        // table walk: R4 order, R5 capture phase, R6 idle after six, R8 transfer
        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i], "R4 R5 R6 R8 table");
        end
        check_val("R4 ascending ch0", int'(out_words[9:0]), 505 - 505 + 205);
        check_val("R5 falling capture ch5", int'(out_words[59:50]), 200);

        // R2 addressed load, visible only after transfer
        step(mk(1, 0, 2, 1, 0, 10'h3C3, 10'h155), "R2 addressed load");
        step(mk(1, 0, 6, 0, 1, 0, 0), "R2 transfer");
        check_val("R2 ch2 word", int'(out_words[29:20]), 10'h155);

        // R3 no load for address 6 or deselected channel
        step(mk(1, 0, 6, 1, 0, 0, 10'h3FF), "R3 address 6");
        step(mk(1, 0, 4, 0, 0, 0, 10'h3FF), "R3 chip select low");
        step(mk(1, 0, 6, 0, 1, 0, 0), "R3 transfer");
        check_val("R3 ch4 kept", int'(out_words[49:40]), 201);

        // R7 abort mid-sequence
        step(mk(1, 0, 7, 1, 0, 0, 0), "R7 start");
        step(mk(1, 0, 7, 0, 0, 10'h011, 10'h300), "R7 slot0");
        step(mk(1, 0, 7, 0, 0, 10'h022, 10'h300), "R7 slot1");
        step(mk(1, 0, 3, 0, 0, 10'h3FF, 10'h3FF), "R7 abort");
        step(mk(1, 0, 7, 0, 0, 10'h2AA, 10'h2AA), "R7 after abort");
        step(mk(1, 0, 7, 0, 1, 10'h2AA, 10'h2AA), "R7 after abort xfer");
        check_val("R7 ch2 untouched", int'(out_words[29:20]), 10'h155);
        check_val("R7 ch1 loaded", int'(out_words[19:10]), 10'h022);

        // R9 direct follow mode
        step(mk(1, 0, 1, 1, 1, 0, 5), "R9 follow 1");
        step(mk(1, 0, 1, 1, 1, 0, 6), "R9 follow 2");
        check_val("R10 ch1 bit slice", int'(out_words[19:10]), 6);

        // R1 standby clears both stages
        #2;
        stby = 1'b1;
        #1;
        model_clear();
        check_outs("R1 standby clear");
        @(negedge clk);
        #1;
        stby = 1'b0;
        step(mk(1, 0, 6, 0, 1, 0, 0), "R1 first stage cleared");
        check_val("R1 ch3 zero", int'(out_words[39:30]), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule